// File: doc/BRIEF.md
# Per-pin DDR/SDR input capture stage

This block conditions one serial input pin before it reaches the core. A bypass path hands the raw pin level to the core twice, once for use as combinational data and once for use as a clock source. In single-rate mode the pin is sampled once per rising edge of the system clock. In double-rate mode the pin is captured on both edges of a source strobe. The two samples are paired in the strobe domain and then retimed into the system clock domain.

The retiming registers can act on the rising or the falling edge of the system clock, and a run-time polarity input makes that choice. The purpose is to leave enough timing margin when the strobe phase is unfavourable. A synchronous reset and a clock enable act on every system-domain register. The strobe-domain capture flops have neither. An input delay element is treated as an ideal wire, so it has no representation here.

Top module: `pin_capture`

## Requirements
- R1: `byp_data` and `byp_clk` both follow `din` combinationally, with no register in the path.
- R2: With `ddr_mode`=0, `ce`=1 and `rst`=0, `sdr_q` takes the value `din` had at each rising edge of `sclk`.
- R3: With `ddr_mode`=1, a rising `strobe` edge captures the even bit of a pair, and the following falling edge captures the odd bit.
- R4: The even bit and the odd bit of a strobe cycle reach the system domain as one pair. `even_q` and `odd_q` change together, and the even bit is the one captured first.
- R5: With `sync_pol`=0, `even_q`/`odd_q` take a new pair only on rising `sclk` edges. A pair completed by a rising strobe edge appears at the next rising `sclk` edge.
- R6: With `sync_pol`=1, `even_q`/`odd_q` take a new pair only on falling `sclk` edges, at the first falling edge after the pair completes.
- R7: With `ddr_mode`=0, `even_q` and `odd_q` hold their value. With `ddr_mode`=1, `sdr_q` holds its value.
- R8: `rst`=1 (active high) across a full `sclk` cycle clears `sdr_q`, `even_q` and `odd_q` to 0 for either `sync_pol` value, and this takes priority over `ce`.
- R9: With `ce`=0, `sdr_q`, `even_q` and `odd_q` hold their value whatever `din` and `strobe` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the system-domain registers |
| ddr_mode | input | 1 | 1 selects double-rate capture, 0 selects single-rate |
| sync_pol | input | 1 | Retiming edge: 0 rising, 1 falling `sclk` |
| strobe | input | 1 | Source strobe for double-rate capture |
| din | input | 1 | Pin data |
| byp_data | output | 1 | Raw pin, for use as data |
| byp_clk | output | 1 | Raw pin, for use as a clock |
| sdr_q | output | 1 | Single-rate registered data |
| even_q | output | 1 | Double-rate stream, rising-strobe bit |
| odd_q | output | 1 | Double-rate stream, falling-strobe bit |

## Verification
If the strobe-side pairing register is missing or wired wrongly, the even and odd bits come from adjacent strobe cycles. The output pair then stops matching the driven even/odd sequence at the first pair after the stream starts. If a retiming bank has the wrong edge or the wrong enable, the pair appears half a system cycle early or late, or keeps changing while it should hold. Checks that sample just after the expected edge catch this within one cycle. A fault in reset or hold logic shows at the next system edge as a nonzero or changed output.

// File: rtl/pin_capture.sv
module pin_capture (
  input  logic sclk,
  input  logic rst,
  input  logic ce,
  input  logic ddr_mode,
  input  logic sync_pol,
  input  logic strobe,
  input  logic din,
  output logic byp_data,
  output logic byp_clk,
  output logic sdr_q,
  output logic even_q,
  output logic odd_q
);

  logic pos_q, neg_q, even_s, odd_s;
  logic rise_even, rise_odd, fall_even, fall_odd;
  logic ddr_en;

  assign byp_data = din;
  assign byp_clk  = din;
  assign ddr_en   = ce & ddr_mode;

  // strobe domain: capture both edges, then pair on the next rising edge
  always_ff @(posedge strobe) begin
    pos_q  <= din;
    even_s <= pos_q;
    odd_s  <= neg_q;
  end

  always_ff @(negedge strobe)
    neg_q <= din;

  always_ff @(posedge sclk)
    if (rst)                  sdr_q <= 1'b0;
    else if (ce && !ddr_mode) sdr_q <= din;

  // two retiming banks, one per system-clock edge
  always_ff @(posedge sclk)
    if (rst) begin
      rise_even <= 1'b0;
      rise_odd  <= 1'b0;
    end else if (ddr_en) begin
      rise_even <= even_s;
      rise_odd  <= odd_s;
    end

  always_ff @(negedge sclk)
    if (rst) begin
      fall_even <= 1'b0;
      fall_odd  <= 1'b0;
    end else if (ddr_en) begin
      fall_even <= even_s;
      fall_odd  <= odd_s;
    end

  assign even_q = sync_pol ? fall_even : rise_even;
  assign odd_q  = sync_pol ? fall_odd  : rise_odd;

  p_sdr_capture_r2: assert property (@(posedge sclk) disable iff (rst)
    (ce && !ddr_mode) |=> (sdr_q == $past(din)));

  p_rise_pair_r5: assert property (@(posedge sclk) disable iff (rst)
    ddr_en |=> (rise_even == $past(even_s) && rise_odd == $past(odd_s)));

  p_mode_hold_r7: assert property (@(posedge sclk) disable iff (rst)
    !ddr_mode |=> ($stable(rise_even) && $stable(rise_odd)));

  p_sdr_idle_r7: assert property (@(posedge sclk) disable iff (rst)
    ddr_mode |=> $stable(sdr_q));

  p_rise_clear_r8: assert property (@(posedge sclk)
    rst |=> (!sdr_q && !rise_even && !rise_odd));

  p_fall_clear_r8: assert property (@(negedge sclk)
    rst |=> (!fall_even && !fall_odd));

  p_ce_hold_r9: assert property (@(posedge sclk) disable iff (rst)
    !ce |=> ($stable(sdr_q) && $stable(rise_even) && $stable(rise_odd)));

endmodule

// File: tb/pin_capture_tb.sv
module pin_capture_tb;

  logic sclk, rst, ce, ddr_mode, sync_pol, strobe, din;
  logic byp_data, byp_clk, sdr_q, even_q, odd_q;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  pin_capture u_dut (
    .sclk(sclk), .rst(rst), .ce(ce), .ddr_mode(ddr_mode), .sync_pol(sync_pol),
    .strobe(strobe), .din(din), .byp_data(byp_data), .byp_clk(byp_clk),
    .sdr_q(sdr_q), .even_q(even_q), .odd_q(odd_q));

  // 125 MHz: rising edges at 8m+4 ns
  initial begin sclk = 0; forever #4 sclk = ~sclk; end
  // strobe at the same rate, rising edges at 8m+2 ns
  initial begin strobe = 0; #2; forever begin strobe = 1; #4; strobe = 0; #4; end end

  // {sync_pol, 16-bit stream sent LSB first; bit 2j even, bit 2j+1 odd}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0FF0}, {1'b0, 16'h6996},
    {1'b1, 16'hA5C3}, {1'b1, 16'h3C5A}, {1'b1, 16'hF00D}};

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge sclk);
    #1;
  endtask

  task automatic run_stream(input logic [16:0] v);
    logic [15:0] pat;
    pat = v[15:0];
    sync_pol = v[16];
    @(posedge sclk); #4;
    fork
      for (int i = 0; i < 16; i++) begin din = pat[i]; #4; end
      begin
        #(v[16] ? 18 : 14);
        for (int j = 0; j < 8; j++) begin
          check(even_q, pat[2*j],   v[16] ? "R6 R3 R4 even" : "R5 R3 R4 even");
          check(odd_q,  pat[2*j+1], v[16] ? "R6 R3 R4 odd"  : "R5 R3 R4 odd");
          #8;
        end
      end
    join
  endtask

  initial begin
    logic hold_e, hold_o, hold_s;
    rst = 1; ce = 0; ddr_mode = 0; sync_pol = 0; din = 0;
    tick(3);
    rst = 0;
    check(sdr_q, 0, "R8 sdr");
    check(even_q, 0, "R8 even rise");
    sync_pol = 1; #1;
    check(odd_q, 0, "R8 odd fall");
    sync_pol = 0;
    ce = 1;

    // R1 bypass
    din = 1; #1;
    check(byp_data, 1, "R1 data"); check(byp_clk, 1, "R1 clk");
    din = 0; #1;
    check(byp_data, 0, "R1 data"); check(byp_clk, 0, "R1 clk");

    // R2 single-rate sampling
    din = 1; tick(1); check(sdr_q, 1, "R2");
    din = 0; tick(1); check(sdr_q, 0, "R2");
    din = 1; tick(1); check(sdr_q, 1, "R2");

    // R3-R6 vector walk
    ddr_mode = 1;
    foreach (VEC[k]) run_stream(VEC[k]);
    check(sdr_q, 1, "R7 sdr held in DDR");

    // R7 DDR outputs hold in SDR mode
    tick(1);
    sync_pol = 0; ddr_mode = 0; #1;
    hold_e = even_q; hold_o = odd_q;
    for (int i = 0; i < 6; i++) begin din = ~din; tick(1); end
    check(even_q, hold_e, "R7 even hold");
    check(odd_q, hold_o, "R7 odd hold");

    // R9 enable low holds
    din = 0; tick(1);
    hold_s = sdr_q;
    ce = 0;
    for (int i = 0; i < 4; i++) begin din = ~hold_s; tick(1); end
    check(sdr_q, hold_s, "R9 sdr");
    ddr_mode = 1; #1;
    hold_e = even_q; hold_o = odd_q;
    for (int i = 0; i < 6; i++) begin din = ~din; tick(1); end
    check(even_q, hold_e, "R9 even");
    check(odd_q, hold_o, "R9 odd");

    // R8 reset after activity, enable low
    ce = 1; ddr_mode = 0; din = 1; tick(1);
    ddr_mode = 1;
    for (int i = 0; i < 4; i++) begin din = 1; tick(1); end
    check(even_q, 1, "R8 precondition");
    ce = 0; rst = 1; tick(2); rst = 0;
    check(sdr_q, 0, "R8 sdr");
    check(even_q, 0, "R8 even rise"); check(odd_q, 0, "R8 odd rise");
    sync_pol = 1; #1;
    check(even_q, 0, "R8 even fall"); check(odd_q, 0, "R8 odd fall");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule